// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

The aggregator merges level-sensitive interrupt requests from a population of devices onto a small number of shared interrupt lines. Every device has four request pins. A change on a pin arrives as one event carrying the device index, the pin number and the new level, qualified by a valid strobe. The block remembers the last level of every device pin. When an event carries a real change, the block steers the pin to one shared line and moves that line's count of active requesters up or down. A line is driven high while its count is above zero.

Steering rotates pins by slot so that neighbouring devices spread across the lines. The slot is the device index with its low function bits removed. The line number is the pin number plus the slot, taken modulo the line count. The per-line counts are always visible for saving. They can be written back in one cycle. The restore carries a line-count header, and the block refuses a restore whose header does not match its own configuration.

Top module: `irq_line_merger`

## Requirements
- R1: After a synchronous active-low reset, all stored pin levels and all line counts are zero, so every bit of `line_out` is low.
- R2: An event whose level equals the stored level of that device pin is ignored: no count and no output changes.
- R3: An event that raises a stored level stores the new level and adds one to the count of the routed line, with the result visible from the clock edge that takes the event.
- R4: An event that lowers a stored level stores the new level and subtracts one from the count of the routed line.
- R5: `line_out[k]` is high exactly when the count of line k is nonzero.
- R6: The routed line is (pin + (device index >> FN_BITS)) modulo N_LINE. Pins are numbered 0 to 3.
- R7: `cnt_flat` presents the count of line k in bits [k*CW +: CW], where CW = clog2(4*N_DEV+1).
- R8: A restore with `ld_nline` equal to N_LINE replaces every count with `ld_cnt` (same layout as `cnt_flat`) at the next edge. On a mismatched header, the counts stay unchanged and `ld_reject` is high for the one cycle after that edge.
- R9: A lowering event on a line whose count is zero leaves the count at zero. In that case `underflow_err` is high for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | Pin level event strobe |
| ev_dev | input | DEV_W | Device index of the event |
| ev_pin | input | 2 | Pin number 0..3 |
| ev_level | input | 1 | New level of the pin |
| ld_valid | input | 1 | Restore strobe |
| ld_nline | input | 8 | Line count carried by the restore image |
| ld_cnt | input | N_LINE*CW | Counts to restore |
| line_out | output | N_LINE | Shared interrupt line levels |
| cnt_flat | output | N_LINE*CW | Current counts, for saving |
| ld_reject | output | 1 | Restore refused (one-cycle pulse) |
| underflow_err | output | 1 | Decrement at zero (one-cycle pulse) |

## Verification
Several devices in the same slot raise the same pin. This shows that a line is held by a count and not by the last event: the line must stay high until the final requester drops. Repeating the same level, and dropping a pin that is already low, separate real changes from redundant events. Devices in different slots raising different pins land on computed lines, and this exposes rotation or modulo errors. Restores with a correct header and with a wrong header, followed by a drop on a line that was zeroed, exercise the reject path and the saturating underflow path.

// File: rtl/irqm_pkg.sv
// Package: shared constants for the interrupt line aggregator.
// Assumes: the restore header is a plain binary line count.
package irqm_pkg;
    localparam int PINS_PER_DEV = 4;
    localparam int PIN_W        = 2;
    localparam int HDR_W        = 8;
endpackage

// File: rtl/irqm_route.sv
// Module: irqm_route
// Maps a device pin to a shared line: (pin + slot) mod N_LINE, with the
// slot being the device index shifted right by FN_BITS.
// Assumes: purely combinational; the caller qualifies the result.
module irqm_route #(
    parameter int N_DEV   = 16,
    parameter int N_LINE  = 4,
    parameter int FN_BITS = 2,
    localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int LW     = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
    input  logic [DEV_W-1:0]              dev,
    input  logic [irqm_pkg::PIN_W-1:0]    pin,
    output logic [LW-1:0]                 line_idx,
    output logic [N_LINE-1:0]             line_hot
);
    // Compute the routed line number and its one-hot form.
    always_comb begin
        int sum;
        sum      = (int'(dev) >> FN_BITS) + int'(pin);
        line_idx = LW'(sum % N_LINE);
        line_hot = '0;
        line_hot[line_idx] = 1'b1;
    end
endmodule

// File: rtl/irqm_pin_store.sv
// Module: irqm_pin_store
// Holds the last level of every device pin and flags events that change it.
// Assumes: the index {dev, pin} addresses a flat vector of N_DEV*4 bits.
module irqm_pin_store #(
    parameter int N_DEV  = 16,
    localparam int DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int NBITS = N_DEV * irqm_pkg::PINS_PER_DEV
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ev_valid,
    input  logic [DEV_W-1:0]              ev_dev,
    input  logic [irqm_pkg::PIN_W-1:0]    ev_pin,
    input  logic                          ev_level,
    output logic                          changed
);
    logic [NBITS-1:0] lvl_q;
    logic [DEV_W+irqm_pkg::PIN_W-1:0] bit_idx;

    // Form the flat bit index and detect a real level change.
    always_comb begin
        bit_idx = {ev_dev, ev_pin};
        changed = ev_valid && (lvl_q[bit_idx] != ev_level);
    end

    // Store the new level on a real change; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       lvl_q <= '0;
        else if (changed) lvl_q[bit_idx] <= ev_level;
    end
endmodule

// File: rtl/irqm_line_cnt.sv
// Module: irqm_line_cnt
// One active-requester counter per shared line, with bulk load and
// saturating decrement that reports an attempted underflow.
// Assumes: inc and dec are never both set for the same line.
module irqm_line_cnt #(
    parameter int N_LINE = 4,
    parameter int CW     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_LINE-1:0]    inc,
    input  logic [N_LINE-1:0]    dec,
    input  logic                 ld_en,
    input  logic [N_LINE*CW-1:0] ld_val,
    output logic [N_LINE*CW-1:0] cnt_flat,
    output logic [N_LINE-1:0]    uf
);
    for (genvar k = 0; k < N_LINE; k++) begin : g_line
        logic [CW-1:0] cnt_q;
        logic          uf_q;

        // Update this line's count: load wins, then increment, then decrement.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                uf_q  <= 1'b0;
            end else begin
                uf_q <= 1'b0;
                if (ld_en)       cnt_q <= ld_val[k*CW +: CW];
                else if (inc[k]) cnt_q <= cnt_q + 1'b1;
                else if (dec[k]) begin
                    if (cnt_q == '0) uf_q  <= 1'b1;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            end
        end

        assign cnt_flat[k*CW +: CW] = cnt_q;
        assign uf[k]                = uf_q;
    end
endmodule

// File: rtl/irq_line_merger.sv
// Module: irq_line_merger (top)
// Merges per-device, per-pin level events onto N_LINE shared lines using
// per-line requester counts; exposes counts for save and accepts restores.
// Assumes: a restore and an event in the same cycle is not used; if it
// happens, the restore decides the counts.
module irq_line_merger #(
    parameter int N_DEV   = 16,
    parameter int N_LINE  = 4,
    parameter int FN_BITS = 2,
    localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int LW     = (N_LINE > 1) ? $clog2(N_LINE) : 1,
    localparam int CW     = $clog2(N_DEV * irqm_pkg::PINS_PER_DEV + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ev_valid,
    input  logic [DEV_W-1:0]              ev_dev,
    input  logic [irqm_pkg::PIN_W-1:0]    ev_pin,
    input  logic                          ev_level,
    input  logic                          ld_valid,
    input  logic [irqm_pkg::HDR_W-1:0]    ld_nline,
    input  logic [N_LINE*CW-1:0]          ld_cnt,
    output logic [N_LINE-1:0]             line_out,
    output logic [N_LINE*CW-1:0]          cnt_flat,
    output logic                          ld_reject,
    output logic                          underflow_err
);
    logic [LW-1:0]     route_idx;
    logic [N_LINE-1:0] route_hot;
    logic              chg;
    logic              ld_ok;
    logic [N_LINE-1:0] inc_v, dec_v, uf_v;

    irqm_route #(.N_DEV(N_DEV), .N_LINE(N_LINE), .FN_BITS(FN_BITS)) u_route (
        .dev(ev_dev), .pin(ev_pin), .line_idx(route_idx), .line_hot(route_hot)
    );

    irqm_pin_store #(.N_DEV(N_DEV)) u_store (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_dev(ev_dev),
        .ev_pin(ev_pin), .ev_level(ev_level), .changed(chg)
    );

    // Steer a real change to the increment or decrement of the routed line.
    always_comb begin
        ld_ok = ld_valid && (ld_nline == irqm_pkg::HDR_W'(N_LINE));
        inc_v = (chg &&  ev_level) ? route_hot : '0;
        dec_v = (chg && !ev_level) ? route_hot : '0;
    end

    irqm_line_cnt #(.N_LINE(N_LINE), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc_v), .dec(dec_v),
        .ld_en(ld_ok), .ld_val(ld_cnt), .cnt_flat(cnt_flat), .uf(uf_v)
    );

    // Drive each shared line from its count being nonzero.
    always_comb begin
        for (int k = 0; k < N_LINE; k++)
            line_out[k] = (cnt_flat[k*CW +: CW] != '0);
    end

    // Pulse the restore-refused flag for a mismatched header.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_reject <= 1'b0;
        else        ld_reject <= ld_valid && !ld_ok;
    end

    assign underflow_err = |uf_v;
endmodule

// File: rtl/irq_line_merger_chk.sv
// Module: irq_line_merger_chk
// Temporal checks on the aggregator, attached to every instance by bind.
// Assumes: sees the top ports plus the change flag and routed one-hot line.
module irq_line_merger_chk #(
    parameter int N_LINE = 4,
    parameter int CW     = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ev_valid,
    input logic                       ev_level,
    input logic                       ld_valid,
    input logic [7:0]                 ld_nline,
    input logic [N_LINE-1:0]          line_out,
    input logic [N_LINE*CW-1:0]       cnt_flat,
    input logic                       ld_reject,
    input logic                       underflow_err,
    input logic                       chg,
    input logic [N_LINE-1:0]          route_hot
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (line_out == '0 && cnt_flat == '0)); // R1
    AST_SAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !chg && !ld_valid) |=> ($stable(cnt_flat) && $stable(line_out))); // R2
    AST_RISE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && ev_level && !ld_valid) |=> ((line_out & $past(route_hot)) == $past(route_hot))); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !ld_valid) |=> ($stable(cnt_flat) && $stable(line_out))); // R5
    AST_BAD_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_nline != 8'(N_LINE) && !ev_valid) |=> (ld_reject && $stable(cnt_flat))); // R8
    AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |-> $past(chg && !ev_level)); // R9
endmodule

bind irq_line_merger irq_line_merger_chk #(.N_LINE(N_LINE), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_level(ev_level),
    .ld_valid(ld_valid), .ld_nline(ld_nline), .line_out(line_out),
    .cnt_flat(cnt_flat), .ld_reject(ld_reject), .underflow_err(underflow_err),
    .chg(chg), .route_hot(route_hot)
);

// File: tb/test_irq_line_merger.sv
module test_irq_line_merger;
    localparam int CLK_PERIOD = 10;
    localparam int N_DEV  = 16;
    localparam int N_LINE = 4;
    localparam int FN_BITS = 2;
    localparam int CW = $clog2(N_DEV * 4 + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0;
    logic [3:0] ev_dev = '0;
    logic [1:0] ev_pin = '0;
    logic ev_level = 1'b0;
    logic ld_valid = 1'b0;
    logic [7:0] ld_nline = '0;
    logic [N_LINE*CW-1:0] ld_cnt = '0;
    logic [N_LINE-1:0] line_out;
    logic [N_LINE*CW-1:0] cnt_flat;
    logic ld_reject, underflow_err;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt [N_LINE];
    logic exp_lvl [N_DEV][4];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_line_merger #(.N_DEV(N_DEV), .N_LINE(N_LINE), .FN_BITS(FN_BITS)) i_irq_line_merger (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_dev(ev_dev),
        .ev_pin(ev_pin), .ev_level(ev_level), .ld_valid(ld_valid),
        .ld_nline(ld_nline), .ld_cnt(ld_cnt), .line_out(line_out),
        .cnt_flat(cnt_flat), .ld_reject(ld_reject), .underflow_err(underflow_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare every count and line level against the model.
    task automatic check_all(input string req);
        for (int k = 0; k < N_LINE; k++) begin
            check(int'(cnt_flat[k*CW +: CW]) == exp_cnt[k], req, cnt_flat[k*CW +: CW], exp_cnt[k]);
            check(line_out[k] == (exp_cnt[k] != 0), req, line_out[k], exp_cnt[k] != 0);
        end
    endtask

    // Send one event and update the model from the requirements.
    task automatic send(input int dev, input int pin, input bit lvl, output bit uf_exp);
        int ln;
        ln = ((dev >> FN_BITS) + pin) % N_LINE;
        uf_exp = 1'b0;
        @(negedge clk);
        ev_valid = 1'b1; ev_dev = 4'(dev); ev_pin = 2'(pin); ev_level = lvl;
        @(negedge clk);
        ev_valid = 1'b0;
        if (exp_lvl[dev][pin] != lvl) begin
            exp_lvl[dev][pin] = lvl;
            if (lvl) exp_cnt[ln]++;
            else if (exp_cnt[ln] == 0) uf_exp = 1'b1;
            else exp_cnt[ln]--;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < N_LINE; k++) exp_cnt[k] = 0;
        for (int d = 0; d < N_DEV; d++) for (int p = 0; p < 4; p++) exp_lvl[d][p] = 1'b0;
        check_all("R1");
        check(line_out == '0, "R1", line_out, 0);
    endtask

    task automatic t_shared_line;
        bit u;
        send(0, 0, 1'b1, u); check_all("R3");
        send(0, 0, 1'b1, u); check_all("R2");
        send(1, 0, 1'b1, u); check_all("R3");
        check(int'(cnt_flat[0 +: CW]) == 2, "R7", cnt_flat[0 +: CW], 2);
        send(0, 0, 1'b0, u); check_all("R4");
        check(line_out[0] == 1'b1, "R5", line_out[0], 1);
        send(1, 0, 1'b0, u); check_all("R4");
        check(line_out[0] == 1'b0, "R5", line_out[0], 0);
        send(2, 3, 1'b0, u); check_all("R2");
        check(underflow_err == 1'b0, "R2", underflow_err, 0);
    endtask

    task automatic t_routing;
        bit u;
        send(4, 3, 1'b1, u);  check(int'(cnt_flat[0 +: CW]) == 1, "R6", cnt_flat[0 +: CW], 1);
        send(13, 1, 1'b1, u); check(int'(cnt_flat[0 +: CW]) == 2, "R6", cnt_flat[0 +: CW], 2);
        send(6, 2, 1'b1, u);  check(int'(cnt_flat[3*CW +: CW]) == 1, "R6", cnt_flat[3*CW +: CW], 1);
        send(9, 0, 1'b1, u);  check(int'(cnt_flat[2*CW +: CW]) == 1, "R6", cnt_flat[2*CW +: CW], 1);
        check_all("R6");
    endtask

    task automatic t_restore;
        logic [N_LINE*CW-1:0] img;
        for (int k = 0; k < N_LINE; k++) img[k*CW +: CW] = CW'(k + 5);
        @(negedge clk);
        ld_valid = 1'b1; ld_nline = 8'd3; ld_cnt = img;
        @(negedge clk);
        ld_valid = 1'b0;
        check(ld_reject == 1'b1, "R8", ld_reject, 1);
        check_all("R8");
        @(negedge clk);
        check(ld_reject == 1'b0, "R8", ld_reject, 0);
        ld_valid = 1'b1; ld_nline = 8'(N_LINE); ld_cnt = img;
        @(negedge clk);
        ld_valid = 1'b0;
        for (int k = 0; k < N_LINE; k++) exp_cnt[k] = k + 5;
        check(ld_reject == 1'b0, "R8", ld_reject, 0);
        check_all("R8");
    endtask

    task automatic t_underflow;
        bit u;
        @(negedge clk);
        ld_valid = 1'b1; ld_nline = 8'(N_LINE); ld_cnt = '0;
        @(negedge clk);
        ld_valid = 1'b0;
        for (int k = 0; k < N_LINE; k++) exp_cnt[k] = 0;
        check_all("R8");
        send(4, 3, 1'b0, u);
        check(underflow_err == u && u, "R9", underflow_err, 1);
        check_all("R9");
        @(negedge clk);
        check(underflow_err == 1'b0, "R9", underflow_err, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_shared_line();
                t_routing();
                t_restore();
                t_underflow();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule